// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

A small, fully associative table of segment descriptors for an address-translation unit. Every entry holds two 64-bit words: an effective-segment word that carries the segment number and a valid flag, and a virtual-segment word that carries a size code and the attribute bits. An effective address presented on the lookup port is compared with every entry in the same cycle. The index and virtual-segment word of the lowest-numbered matching entry are returned. Each entry matches at 256 MB or 1 TB granularity, as chosen by its own size code.

A maintenance port takes one operation per cycle. It can write an entry by slot number, after checking the operands. It can read either word of an entry by slot number. It can invalidate the entry that matches an address, or invalidate every entry except slot 0. A rejected operation raises a one-cycle error pulse and changes nothing. An invalidation that actually cleared a valid entry raises a one-cycle request to flush the downstream translation cache. The entry count `ENTRIES` is a power of two, between 2 and 4096, with a default of 64.

Top module: `slb_array`

## Requirements
- R1: An entry hits a lookup when its segment word equals the address bits [63:28] with bit 27 (the valid flag) set and bits [26:0] clear, and its size code (virtual word bits [63:62]) is 00.
- R2: An entry also hits when its segment word equals the address bits [63:40] with bits [39:28] clear, bit 27 set and bits [26:0] clear, and its size code is 01. When several entries hit, the lowest index is reported.
- R3: Lookup is combinational. On a hit, `lk_hit`=1, `lk_index` is the entry index and `lk_vsid` is that entry's stored virtual word. On a miss, all three are 0.
- R4: The slot number is `op_addr[11:0]`. A write (`op_kind`=0) to a slot at or above `ENTRIES` is rejected.
- R5: A write is rejected when `op_data[63:62]` is 10 or 11, or when it is 01 and `cfg_1t_en` is 0.
- R6: An accepted write stores `op_addr` with bits [26:0] cleared as the segment word, and `op_data` unchanged as the virtual word. It takes effect at the next clock edge.
- R7: A read of the segment word (`op_kind`=1) or the virtual word (`op_kind`=2) puts the word on `rd_data` one cycle later. A read of a slot at or above `ENTRIES` is rejected and puts 0 on `rd_data`. `rd_data` holds its value until the next read.
- R8: Every rejected operation raises `err_pulse` for exactly the one cycle after the request and leaves the table unchanged.
- R9: Single invalidate (`op_kind`=3) clears bit 27 of the lowest entry that hits `op_addr` under R1/R2, and raises `flush_req` for one cycle. On a miss it does nothing.
- R10: Invalidate-all (`op_kind`=4) clears bit 27 of every entry except entry 0. It raises `flush_req` only if at least one of those entries was valid. `op_kind` values 5 to 7 have no effect.
- R11: Reset clears every entry word, `rd_data`, `err_pulse` and `flush_req` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_1t_en | input | 1 | Allows 1 TB segments to be written |
| lk_ea | input | 64 | Lookup effective address |
| lk_hit | output | 1 | Lookup found an entry |
| lk_index | output | $clog2(ENTRIES) | Index of the lowest hitting entry |
| lk_vsid | output | 64 | Virtual word of the hitting entry |
| op_req | input | 1 | Maintenance operation request |
| op_kind | input | 3 | 0 write, 1 read segment word, 2 read virtual word, 3 invalidate one, 4 invalidate all |
| op_addr | input | 64 | Slot number / segment word / invalidate address |
| op_data | input | 64 | Virtual word to write |
| rd_data | output | 64 | Read result |
| err_pulse | output | 1 | Rejected operation, one cycle |
| flush_req | output | 1 | Translation cache flush request, one cycle |

## Verification
The lookup outputs are due in the same cycle as `lk_ea` and the table contents, so they are compared before any edge. The read data, the error pulse and the flush request come one cycle after the request edge, and a write or invalidation shows up in lookups from that same cycle on. The bench drives each request just after a rising edge and compares every output at the following falling edge against a behavioural model that has applied that edge's request. This keeps each comparison exactly one register stage behind its stimulus.

// File: rtl/slb_pkg.sv
package slb_pkg;
    localparam int WORD_W      = 64;
    localparam int VALID_BIT   = 27;
    localparam int SEG256_LSB  = 28;
    localparam int SEG1T_LSB   = 40;
    localparam int SLOT_W      = 12;
    localparam int SIZE_LSB    = 62;

    localparam logic [1:0] SIZE_256M = 2'b00;
    localparam logic [1:0] SIZE_1T   = 2'b01;

    typedef enum logic [2:0] {
        OP_WRITE   = 3'd0,
        OP_RD_SEG  = 3'd1,
        OP_RD_VIRT = 3'd2,
        OP_INV_ONE = 3'd3,
        OP_INV_ALL = 3'd4
    } slb_op_e;
endpackage

// File: rtl/slb_match.sv
module slb_match
    import slb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [WORD_W-1:SEG256_LSB]        ea_seg,
    input  logic [ENTRIES-1:0][WORD_W-1:0]    seg_tab,
    input  logic [ENTRIES-1:0][1:0]           size_tab,
    output logic                              hit,
    output logic [IDX_W-1:0]                  idx
);
    logic [WORD_W-1:0]  tag_small;
    logic [WORD_W-1:0]  tag_large;
    logic [ENTRIES-1:0] hit_vec;

    assign tag_small = {ea_seg, 1'b1, {VALID_BIT{1'b0}}};
    assign tag_large = {ea_seg[WORD_W-1:SEG1T_LSB],
                        {(SEG1T_LSB-SEG256_LSB){1'b0}}, 1'b1, {VALID_BIT{1'b0}}};

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = ((seg_tab[g] == tag_small) && (size_tab[g] == SIZE_256M))
                         || ((seg_tab[g] == tag_large) && (size_tab[g] == SIZE_1T));
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/slb_wcheck.sv
module slb_wcheck
    import slb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [1:0]        size_code,
    input  logic              cfg_1t_en,
    output logic              ok
);
    localparam logic [SLOT_W-1:0] SLOT_RSV = ~SLOT_W'(ENTRIES - 1);

    logic slot_bad;
    logic size_ok;

    always_comb begin
        slot_bad = |(slot & SLOT_RSV);
        size_ok  = (size_code == SIZE_256M) || ((size_code == SIZE_1T) && cfg_1t_en);
        ok       = !slot_bad && size_ok;
    end
endmodule

// File: rtl/slb_array.sv
module slb_array
    import slb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_1t_en,
    input  logic [63:0]       lk_ea,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_index,
    output logic [63:0]       lk_vsid,
    input  logic              op_req,
    input  logic [2:0]        op_kind,
    input  logic [63:0]       op_addr,
    input  logic [63:0]       op_data,
    output logic [63:0]       rd_data,
    output logic              err_pulse,
    output logic              flush_req
);
    localparam logic [WORD_W-1:0] SEG_KEEP = ~((WORD_W'(1) << VALID_BIT) - WORD_W'(1));

    typedef struct packed {
        logic [ENTRIES-1:0][WORD_W-1:0] seg;
        logic [ENTRIES-1:0][WORD_W-1:0] virt;
        logic [WORD_W-1:0]              rd;
        logic                           err;
        logic                           flush;
    } state_t;

    state_t s_d, s_q;

    logic [ENTRIES-1:0][1:0] size_tab;
    logic [ENTRIES-1:0]      valid_vec;
    logic                    inv_hit;
    logic [IDX_W-1:0]        inv_idx;
    logic                    wr_ok;
    logic                    rd_ok;
    logic [IDX_W-1:0]        slot_idx;
    logic                    unused_lk;

    assign unused_lk = ^lk_ea[SEG256_LSB-1:0];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_fields
        assign size_tab[g]  = s_q.virt[g][SIZE_LSB+1:SIZE_LSB];
        assign valid_vec[g] = s_q.seg[g][VALID_BIT];
    end

    slb_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .ea_seg   (lk_ea[WORD_W-1:SEG256_LSB]),
        .seg_tab  (s_q.seg),
        .size_tab (size_tab),
        .hit      (lk_hit),
        .idx      (lk_index)
    );

    slb_match #(.ENTRIES(ENTRIES)) u_inv_match (
        .ea_seg   (op_addr[WORD_W-1:SEG256_LSB]),
        .seg_tab  (s_q.seg),
        .size_tab (size_tab),
        .hit      (inv_hit),
        .idx      (inv_idx)
    );

    slb_wcheck #(.ENTRIES(ENTRIES)) u_wcheck (
        .slot      (op_addr[SLOT_W-1:0]),
        .size_code (op_data[SIZE_LSB+1:SIZE_LSB]),
        .cfg_1t_en (cfg_1t_en),
        .ok        (wr_ok)
    );

    assign lk_vsid   = lk_hit ? s_q.virt[lk_index] : '0;
    assign rd_ok     = int'(op_addr[SLOT_W-1:0]) < ENTRIES;
    assign slot_idx  = op_addr[IDX_W-1:0];
    assign rd_data   = s_q.rd;
    assign err_pulse = s_q.err;
    assign flush_req = s_q.flush;

    always_comb begin
        s_d       = s_q;
        s_d.err   = 1'b0;
        s_d.flush = 1'b0;
        if (op_req) begin
            case (slb_op_e'(op_kind))
                OP_WRITE: begin
                    if (wr_ok) begin
                        s_d.seg[slot_idx]  = op_addr & SEG_KEEP;
                        s_d.virt[slot_idx] = op_data;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
                OP_RD_SEG: begin
                    s_d.rd  = rd_ok ? s_q.seg[slot_idx] : '0;
                    s_d.err = !rd_ok;
                end
                OP_RD_VIRT: begin
                    s_d.rd  = rd_ok ? s_q.virt[slot_idx] : '0;
                    s_d.err = !rd_ok;
                end
                OP_INV_ONE: begin
                    if (inv_hit) begin
                        s_d.seg[inv_idx][VALID_BIT] = 1'b0;
                        s_d.flush = 1'b1;
                    end
                end
                OP_INV_ALL: begin
                    for (int i = 1; i < ENTRIES; i++) begin
                        if (s_q.seg[i][VALID_BIT]) begin
                            s_d.seg[i][VALID_BIT] = 1'b0;
                            s_d.flush = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_HIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> s_q.seg[lk_index][VALID_BIT]); // R1

    AST_ERR_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_pulse && flush_req)); // R9

    AST_ERR_TABLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && s_d.err) |=> ($stable(s_q.seg) && $stable(s_q.virt))); // R8

    AST_KEEP_ENTRY0: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && op_kind == OP_INV_ALL) |=> $stable(s_q.seg[0])); // R10

    AST_INVALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && op_kind == OP_INV_ALL) |=> (valid_vec[ENTRIES-1:1] == '0)); // R10

    for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
        AST_SEG_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.seg[g][VALID_BIT-1:0] == '0); // R6
        AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            !s_q.virt[g][SIZE_LSB+1]); // R5
    end
endmodule

// File: tb/sim_slb_array.sv
`timescale 1ns/1ps
module sim_slb_array;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_1t_en = 1'b0;
    logic [63:0] lk_ea = '0;
    logic        lk_hit;
    logic [5:0]  lk_index;
    logic [63:0] lk_vsid;
    logic        op_req = 1'b0;
    logic [2:0]  op_kind = '0;
    logic [63:0] op_addr = '0;
    logic [63:0] op_data = '0;
    logic [63:0] rd_data;
    logic        err_pulse;
    logic        flush_req;

    always #2 clk = ~clk;

    slb_array #(.ENTRIES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_1t_en(cfg_1t_en),
        .lk_ea(lk_ea), .lk_hit(lk_hit), .lk_index(lk_index), .lk_vsid(lk_vsid),
        .op_req(op_req), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
        .rd_data(rd_data), .err_pulse(err_pulse), .flush_req(flush_req)
    );

    logic [63:0] m_seg [N];
    logic [63:0] m_virt [N];
    logic [63:0] m_rd;
    logic        m_err, m_flush;
    int          n_chk = 0, n_err = 0;
    string       tag = "R11";
    bit          compare_on = 1'b0;
    bit          finished = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int m_find(input logic [63:0] ea);
        logic [63:0] small_t, large_t;
        small_t = (ea & 64'hFFFF_FFFF_F000_0000) | 64'h0000_0000_0800_0000;
        large_t = (ea & 64'hFFFF_FF00_0000_0000) | 64'h0000_0000_0800_0000;
        for (int i = 0; i < N; i++) begin
            if (m_seg[i] == small_t && m_virt[i][63:62] == 2'b00) return i;
            if (m_seg[i] == large_t && m_virt[i][63:62] == 2'b01) return i;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_seg[i] = '0; m_virt[i] = '0; end
            m_rd = '0; m_err = 0; m_flush = 0;
        end else begin
            int s, h;
            bit any;
            m_err = 0; m_flush = 0;
            s = int'(op_addr[11:0]);
            if (op_req) begin
                case (op_kind)
                    3'd0: begin
                        if (s >= N || op_data[63] ||
                            (op_data[63:62] == 2'b01 && !cfg_1t_en)) m_err = 1;
                        else begin
                            m_seg[s]  = {op_addr[63:27], 27'd0};
                            m_virt[s] = op_data;
                        end
                    end
                    3'd1, 3'd2: begin
                        if (s >= N) begin m_rd = '0; m_err = 1; end
                        else m_rd = (op_kind == 3'd1) ? m_seg[s] : m_virt[s];
                    end
                    3'd3: begin
                        h = m_find(op_addr);
                        if (h >= 0) begin m_seg[h][27] = 1'b0; m_flush = 1; end
                    end
                    3'd4: begin
                        any = 0;
                        for (int i = 1; i < N; i++) begin
                            if (m_seg[i][27]) any = 1;
                            m_seg[i][27] = 1'b0;
                        end
                        m_flush = any;
                    end
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (compare_on && rst_n) begin
            int h;
            h = m_find(lk_ea);
            check(tag, "lk_hit", {63'd0, lk_hit}, {63'd0, h >= 0});
            check(tag, "lk_index", {58'd0, lk_index}, (h >= 0) ? 64'(h) : 64'd0);
            check(tag, "lk_vsid", lk_vsid, (h >= 0) ? m_virt[h] : 64'd0);
            check(tag, "rd_data", rd_data, m_rd);
            check(tag, "err_pulse", {63'd0, err_pulse}, {63'd0, m_err});
            check(tag, "flush_req", {63'd0, flush_req}, {63'd0, m_flush});
        end
    end

    task automatic op(input logic [2:0] k, input logic [63:0] a, input logic [63:0] d);
        @(posedge clk); #1;
        op_req = 1'b1; op_kind = k; op_addr = a; op_data = d;
        @(posedge clk); #1;
        op_req = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [31:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", "reset rd_data", rd_data, 64'd0);
        check("R11", "reset err", {63'd0, err_pulse}, 64'd0);
        check("R11", "reset flush", {63'd0, flush_req}, 64'd0);
        check("R11", "reset lk_hit", {63'd0, lk_hit}, 64'd0);
        @(posedge clk); #1; rst_n = 1'b1; compare_on = 1'b1;

        tag = "R6";
        op(3'd0, 64'h1234_5678_9FFF_F005, 64'h0000_0ABC_DEF0_1234);
        op(3'd1, 64'd5, 64'd0);
        @(negedge clk);
        check("R6", "stripped segment word", rd_data, 64'h1234_5678_9800_0000);
        op(3'd2, 64'd5, 64'd0);
        @(negedge clk);
        check("R7", "virtual word read", rd_data, 64'h0000_0ABC_DEF0_1234);

        tag = "R1";
        lk_ea = 64'h1234_5678_9ABC_DEF0;
        @(negedge clk);
        check("R1", "256M hit", {lk_hit, 57'd0, lk_index}, {1'b1, 57'd0, 6'd5});
        check("R3", "hit vsid", lk_vsid, 64'h0000_0ABC_DEF0_1234);
        lk_ea = 64'h1234_5678_AABC_DEF0;
        @(negedge clk);
        check("R3", "miss outputs", {lk_hit, 57'd0, lk_index}, 64'd0);
        check("R3", "miss vsid", lk_vsid, 64'd0);

        tag = "R2";
        cfg_1t_en = 1'b1;
        op(3'd0, 64'h00AB_CD00_0800_0009, 64'h4000_0000_0000_0777);
        lk_ea = 64'h00AB_CDFF_FFFF_FFFF;
        @(negedge clk);
        check("R2", "1T hit", {lk_hit, 57'd0, lk_index}, {1'b1, 57'd0, 6'd9});
        op(3'd0, 64'h0000_1111_2800_000C, 64'h0000_0000_0000_0C0C);
        op(3'd0, 64'h0000_1111_2800_0014, 64'h0000_0000_0000_1414);
        lk_ea = 64'h0000_1111_2123_4567;
        @(negedge clk);
        check("R2", "lowest index wins", {58'd0, lk_index}, 64'd12);

        tag = "R9";
        op(3'd3, 64'h0000_1111_2000_0000, 64'd0);
        @(negedge clk);
        check("R9", "flush on hit", {63'd0, flush_req}, 64'd1);
        check("R9", "next entry now hits", {58'd0, lk_index}, 64'd20);
        op(3'd3, 64'h0000_1111_2000_0000, 64'd0);
        op(3'd3, 64'h0000_1111_2000_0000, 64'd0);
        @(negedge clk);
        check("R9", "miss no flush", {63'd0, flush_req}, 64'd0);

        tag = "R4";
        op(3'd0, 64'h0000_1111_2800_0040, 64'd0);
        @(negedge clk);
        check("R4", "slot 64 rejected", {63'd0, err_pulse}, 64'd1);
        @(negedge clk);
        check("R8", "error lasts one cycle", {63'd0, err_pulse}, 64'd0);
        op(3'd0, 64'h0000_1111_2800_0FFF, 64'd0);
        op(3'd0, 64'h0000_2222_3800_003F, 64'h0000_0000_0000_3F3F);

        tag = "R5";
        op(3'd0, 64'h0000_3333_3800_0001, 64'h8000_0000_0000_0001);
        @(negedge clk);
        check("R5", "size 10 rejected", {63'd0, err_pulse}, 64'd1);
        op(3'd0, 64'h0000_3333_3800_0001, 64'hC000_0000_0000_0001);
        cfg_1t_en = 1'b0;
        op(3'd0, 64'h0000_3300_0800_0001, 64'h4000_0000_0000_0001);
        @(negedge clk);
        check("R5", "1T disabled rejected", {63'd0, err_pulse}, 64'd1);

        tag = "R7";
        op(3'd1, 64'd64, 64'd0);
        @(negedge clk);
        check("R7", "bad read data", rd_data, 64'd0);
        check("R8", "bad read error", {63'd0, err_pulse}, 64'd1);
        op(3'd2, 64'h0000_0000_0000_0FFF, 64'd0);

        tag = "R10";
        op(3'd0, 64'h0000_4444_4800_0000, 64'h0000_0000_0000_0044);
        op(3'd4, 64'd0, 64'd0);
        @(negedge clk);
        check("R10", "flush when valid cleared", {63'd0, flush_req}, 64'd1);
        lk_ea = 64'h0000_4444_4000_0000;
        @(negedge clk);
        check("R10", "entry 0 kept", {lk_hit, 57'd0, lk_index}, {1'b1, 63'd0});
        op(3'd4, 64'd0, 64'd0);
        @(negedge clk);
        check("R10", "no flush when none valid", {63'd0, flush_req}, 64'd0);
        op(3'd5, 64'h0000_4444_4800_0000, 64'd0);
        @(negedge clk);
        check("R10", "kind 5 no effect", {lk_hit, 63'd0}, {1'b1, 63'd0});

        tag = "R8";
        lf = 32'hACE1_2345;
        for (int n = 0; n < 400; n++) begin
            logic [63:0] a, d;
            logic [11:0] sl;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            case (lf[2:0])
                3'd0: sl = 12'd0;  3'd1: sl = 12'd1;  3'd2: sl = 12'd2;
                3'd3: sl = 12'd3;  3'd4: sl = 12'd63; 3'd5: sl = 12'd64;
                3'd6: sl = 12'd7;  default: sl = 12'hF01;
            endcase
            a = {24'h000055, 4'd0, lf[9:8], 2'b00, 4'd0, lf[10], 15'd0, sl[11:0]};
            a[27] = lf[11];
            d = {lf[13:12], 30'd0, lf[31:0]};
            cfg_1t_en = lf[14];
            lk_ea = {24'h000055, 4'd0, lf[17:16], 2'b00, 4'd0, lf[18], 27'h123_4567};
            op((lf[20:18] == 3'd7) ? 3'd0 : lf[20:18], a, d);
        end
        compare_on = 1'b0;
        summary();
    end
endmodule